// File: doc/BRIEF.md
# Period-Match Timer with Gating

This block is a 16-bit timer peripheral for a system-on-chip. It holds a control register, a count register and a period register, all reached through a simple register port. Writes take effect on the clock edge. Reads are combinational from the read address.

One input pin, `tmr_in`, serves two roles, chosen by the control register:

- **External counter mode:** every synchronized rising edge of the pin is a count-source tick.
- **Gated mode:** the pin acts as a gate. While it is high, the system clock is the count source.
- **Internal mode:** with neither gating nor the external source selected, the block counts the system clock without a gate.

A programmable prescaler sits between the selected source and the count register. When the count reaches the period value, the next count tick returns it to zero. In external and internal modes that wrap is reported by a one-cycle `match_evt` pulse. In gated mode the wrap is silent. The falling edge of the gate stops counting without clearing the count, and it raises a one-cycle `gate_evt` pulse.

The sequencing is held in a five-state machine:

- **OFF:** the timer is disabled.
- **EXT:** external counting.
- **INT:** free internal counting.
- **GATE_IDLE:** gated mode, waiting for the gate to rise.
- **GATE_RUN:** gated mode, counting while the gate is high.

Its transitions are:

- **OFF→EXT:** enable with the source bit set.
- **OFF→INT:** enable with internal source and gating off.
- **OFF→GATE_IDLE:** enable with internal source and gating on.
- **GATE_IDLE→GATE_RUN:** gate rising edge.
- **GATE_RUN→GATE_IDLE:** gate falling edge, which raises `gate_evt`.
- **any→OFF:** enable cleared.

Top module: `pm_gate_timer`

## Requirements
- R1: After reset, all three registers read 0 and `match_evt` and `gate_evt` are low.
- R2: The register map is as follows:
  - Address 0 is control. Bit 15 is enable, bit 7 is gate mode, bits 6:4 are the prescale select, and bit 1 is the source (1 = `tmr_in` edges, 0 = system clock).
  - Address 1 is the count and address 2 is the period.
  - The other control bits read 0, and address 3 reads 0.
- R3: In external mode each rising edge of `tmr_in` (after a two-flop synchronizer) is one source tick.
- R4: Prescale select values 0..7 give ratios 1, 2, 4, 8, 16, 32, 64 and 256. The count advances on every Nth source tick, and the prescaler restarts from zero each time the timer is enabled.
- R5: A count tick that finds count equal to period sets the count to 0. In external and internal modes it also drives `match_evt` high for exactly the following cycle.
- R6: In gated mode a `tmr_in` rising edge starts counting, and the count advances once per clock (before prescaling) for as many cycles as the gate was high. Wrapping still applies, but `match_evt` stays low.
- R7: On the gate's falling edge in gated mode, `gate_evt` pulses for one cycle and counting stops. The count keeps its value until software writes it.
- R8: While enable is 0 the count does not change, except by a register write, and no event is raised.
- R9: A write to the count register loads the written value even in a cycle where the count would increment.
- R10: With source 0 and gate mode 0, the count advances once per clock (before prescaling) while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_in | input | 1 | External count input or gate, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data |
| match_evt | output | 1 | One-cycle period-match pulse |
| gate_evt | output | 1 | One-cycle gate-end pulse |

## Verification
The assertions take for granted that software changes the source, gate and prescale fields only while enable is 0. For example, they assume a match pulse cannot follow a cycle in which gated mode was freshly selected under a running timer. They also assume that `tmr_in` stays high and low for at least one full clock each, so every edge survives the synchronizer.

The stimulus keeps within these assumptions. Every configuration is written as a sequence: disable, clear the count, load the period, then enable. External pulses hold each level for two clocks, and gate pulses are at least three clocks long.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_EXT       = 3'd1,
        ST_INT       = 3'd2,
        ST_GATE_IDLE = 3'd3,
        ST_GATE_RUN  = 3'd4
    } pmt_state_e;

    localparam int CTL_EN_BIT   = 15;
    localparam int CTL_GATE_BIT = 7;
    localparam int CTL_PS_LSB   = 4;
    localparam int CTL_SRC_BIT  = 1;

    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_CNT = 2'd1;
    localparam logic [1:0] ADDR_PER = 2'd2;

    // terminal value of the prescale counter for a select code
    function automatic logic [7:0] ps_limit(input logic [2:0] sel);
        logic [8:0] r;
        if (sel == 3'd7) r = 9'd256;
        else             r = 9'd1 << sel;
        return 8'(r - 9'd1);
    endfunction

endpackage

// File: rtl/pmt_sync_edge.sv
module pmt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;
    logic              lvl;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign lvl = sh_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
    parameter int SEL_W = 3,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_out
);
    import pmt_pkg::*;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;
    logic             at_lim;

    assign lim      = DIV_W'(ps_limit(3'(sel)));
    assign at_lim   = (div_q >= lim);
    assign tick_out = tick_in & at_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (clr)     div_q <= '0;
        else if (tick_in) div_q <= at_lim ? '0 : div_q + 1'b1;
    end
endmodule

// File: rtl/pmt_ctrl_fsm.sv
module pmt_ctrl_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                src_ext,
    input  logic                gate_on,
    input  logic                pin_rise,
    input  logic                pin_fall,
    output pmt_pkg::pmt_state_e st,
    output logic                src_tick,
    output logic                match_ok,
    output logic                gate_end
);
    import pmt_pkg::*;

    pmt_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (en) begin
                    if (src_ext)      st_d = ST_EXT;
                    else if (gate_on) st_d = ST_GATE_IDLE;
                    else              st_d = ST_INT;
                end
            end
            ST_EXT:       if (!en) st_d = ST_OFF;
            ST_INT:       if (!en) st_d = ST_OFF;
            ST_GATE_IDLE: begin
                if (!en)           st_d = ST_OFF;
                else if (pin_rise) st_d = ST_GATE_RUN;
            end
            ST_GATE_RUN: begin
                if (!en)           st_d = ST_OFF;
                else if (pin_fall) st_d = ST_GATE_IDLE;
            end
            default: st_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        src_tick = 1'b0;
        match_ok = 1'b0;
        gate_end = 1'b0;
        unique case (st_q)
            ST_OFF:       ;
            ST_EXT: begin
                src_tick = en & pin_rise;
                match_ok = 1'b1;
            end
            ST_INT: begin
                src_tick = en;
                match_ok = 1'b1;
            end
            ST_GATE_IDLE: ;
            ST_GATE_RUN: begin
                src_tick = en;
                gate_end = en & pin_fall;
            end
            default: ;
        endcase
    end

    assign st = st_q;
endmodule

// File: rtl/pm_gate_timer.sv
module pm_gate_timer #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PS_SEL_W    = 3,
    parameter int DIV_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             match_evt,
    output logic             gate_evt
);
    import pmt_pkg::*;

    localparam int PS_MSB = CTL_PS_LSB + PS_SEL_W - 1;

    logic                en_q, gate_q, src_q;
    logic [PS_SEL_W-1:0] ps_q;
    logic [CNT_W-1:0]    cnt_q, per_q;
    logic                ctl_wr, cnt_wr, per_wr;
    logic                pin_rise, pin_fall;
    logic                src_tick, cnt_tick, match_ok, gate_end, wrap;
    logic                gate_mode;
    pmt_state_e          st;

    assign ctl_wr    = wr_en && (wr_addr == ADDR_CTL);
    assign cnt_wr    = wr_en && (wr_addr == ADDR_CNT);
    assign per_wr    = wr_en && (wr_addr == ADDR_PER);
    assign gate_mode = en_q & ~src_q & gate_q;

    pmt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (tmr_in),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    pmt_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .src_ext (src_q),
        .gate_on (gate_q),
        .pin_rise(pin_rise),
        .pin_fall(pin_fall),
        .st      (st),
        .src_tick(src_tick),
        .match_ok(match_ok),
        .gate_end(gate_end)
    );

    pmt_prescaler #(.SEL_W(PS_SEL_W), .DIV_W(DIV_W)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (~en_q),
        .tick_in (src_tick),
        .sel     (ps_q),
        .tick_out(cnt_tick)
    );

    // control and period registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            gate_q <= 1'b0;
            src_q  <= 1'b0;
            ps_q   <= '0;
            per_q  <= '0;
        end else begin
            if (ctl_wr) begin
                en_q   <= wr_data[CTL_EN_BIT];
                gate_q <= wr_data[CTL_GATE_BIT];
                src_q  <= wr_data[CTL_SRC_BIT];
                ps_q   <= wr_data[PS_MSB:CTL_PS_LSB];
            end
            if (per_wr) per_q <= wr_data;
        end
    end

    assign wrap = (cnt_q == per_q);

    // count register and event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            match_evt <= 1'b0;
            gate_evt  <= 1'b0;
        end else begin
            if (cnt_wr)        cnt_q <= wr_data;
            else if (cnt_tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            match_evt <= cnt_tick & wrap & match_ok & ~cnt_wr;
            gate_evt  <= gate_end;
        end
    end

    // read mux
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTL: begin
                rd_data[CTL_EN_BIT]          = en_q;
                rd_data[CTL_GATE_BIT]        = gate_q;
                rd_data[PS_MSB:CTL_PS_LSB]   = ps_q;
                rd_data[CTL_SRC_BIT]         = src_q;
            end
            ADDR_CNT: rd_data = cnt_q;
            ADDR_PER: rd_data = per_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pmt_chk.sv
module pmt_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             match_evt,
    input logic             gate_evt,
    input logic [CNT_W-1:0] cnt_q,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] wr_data,
    input logic             en_q,
    input logic             gate_mode,
    input logic             in_gate_idle
);
    // R5
    match_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |-> (cnt_q == '0));

    // R6
    no_gated_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |-> !$past(gate_mode));

    // R7
    gate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_evt |=> !gate_evt);

    // R7
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gate_idle && !cnt_wr) |=> $stable(cnt_q));

    // R8
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cnt_wr) |=> $stable(cnt_q));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !$past(en_q)) |-> (!match_evt && !gate_evt));

    // R9
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(wr_data)));
endmodule

bind pm_gate_timer pmt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .match_evt   (match_evt),
    .gate_evt    (gate_evt),
    .cnt_q       (cnt_q),
    .cnt_wr      (cnt_wr),
    .wr_data     (wr_data),
    .en_q        (en_q),
    .gate_mode   (gate_mode),
    .in_gate_idle(st == pmt_pkg::ST_GATE_IDLE)
);

// File: tb/pm_gate_timer_tb.sv
module pm_gate_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        match_evt, gate_evt;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int n_match = 0;
    int n_gate = 0;

    always #2.5 clk = ~clk;

    pm_gate_timer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_in   (tmr_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .match_evt(match_evt),
        .gate_evt (gate_evt)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (match_evt) n_match <= n_match + 1;
        if (gate_evt)  n_gate  <= n_gate + 1;
    end

    initial begin
        wait (cyc >= 190000);
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    function automatic int ratio(input int s);
        return (s == 7) ? 256 : (1 << s);
    endfunction

    // disable, clear count, load period, enable with the given fields
    task automatic cfg(input int fields, input int per);
        wr(2'd0, 0);
        wr(2'd1, 0);
        wr(2'd2, per);
        wr(2'd0, fields | 16'h8000);
        repeat (3) @(negedge clk);
    endtask

    task automatic ext_pulse();
        @(negedge clk); tmr_in = 1'b1;
        repeat (2) @(negedge clk); tmr_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int v, m0, g0, ticks, per, e, s_sum, n_div;
        int hl[4];
        hl[0] = 5; hl[1] = 9; hl[2] = 3; hl[3] = 20;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctl", v, 0);
        rd(2'd1, v); chk("R1 cnt", v, 0);
        rd(2'd2, v); chk("R1 per", v, 0);
        chk("R1 match_evt", int'(match_evt), 0);
        chk("R1 gate_evt", int'(gate_evt), 0);

        // R2 register map
        wr(2'd0, 16'h7FFF);
        rd(2'd0, v); chk("R2 ctl readback", v, 16'h00F2);
        wr(2'd2, 16'hABCD);
        rd(2'd2, v); chk("R2 per readback", v, 16'hABCD);
        wr(2'd1, 16'h1234);
        rd(2'd1, v); chk("R2 cnt readback", v, 16'h1234);
        rd(2'd3, v); chk("R2 addr3", v, 0);
        repeat (4) @(negedge clk);
        rd(2'd1, v); chk("R8 disabled count holds", v, 16'h1234);

        // R3 R4 R5 external counting sweep
        for (int s = 0; s < 8; s++) begin
            for (int pi = 0; pi < 4; pi++) begin
                per = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 3 : 5;
                ticks = 2 * per + 3 + pi;
                e = ratio(s) * ticks + ratio(s) / 2;
                cfg((s << 4) | 2, per);
                m0 = n_match;
                for (int k = 0; k < e; k++) ext_pulse();
                repeat (6) @(negedge clk);
                rd(2'd1, v);
                chk("R3/R4 ext count", v, ticks % (per + 1));
                chk("R5 match pulses", n_match - m0, ticks / (per + 1));
            end
        end

        // R8 disabled: edges ignored
        cfg(2, 16'hFFFF);
        for (int k = 0; k < 7; k++) ext_pulse();
        repeat (6) @(negedge clk);
        wr(2'd0, 2);
        m0 = n_match;
        for (int k = 0; k < 5; k++) ext_pulse();
        repeat (6) @(negedge clk);
        rd(2'd1, v); chk("R8 count frozen when off", v, 7);
        chk("R8 no match when off", n_match - m0, 0);

        // R6 R7 gated mode sweep
        for (int s = 0; s < 4; s++) begin
            cfg((s << 4) | 16'h0080, 7);
            m0 = n_match; g0 = n_gate; s_sum = 0;
            n_div = ratio(s);
            for (int h = 0; h < 4; h++) begin
                @(negedge clk); tmr_in = 1'b1;
                repeat (hl[h]) @(negedge clk);
                tmr_in = 1'b0;
                repeat (8) @(negedge clk);
                s_sum += hl[h];
                rd(2'd1, v);
                chk("R6 gated count", v, (s_sum / n_div) % 8);
                chk("R7 gate events", n_gate - g0, h + 1);
                repeat (10) @(negedge clk);
                rd(2'd1, v);
                chk("R7 count held after gate", v, (s_sum / n_div) % 8);
            end
            chk("R6 no match in gated", n_match - m0, 0);
        end

        // R10 internal counting, prescale 4
        wr(2'd0, 0);
        wr(2'd1, 0);
        wr(2'd2, 16'hFFFF);
        wr(2'd0, 16'h8000 | (2 << 4));
        repeat (41) @(negedge clk);
        rd(2'd1, v); chk("R10 internal count", v, 10);

        // R9 write priority over increment, prescale 1
        cfg(0, 16'hFFFF);
        repeat (10) @(negedge clk);
        wr(2'd1, 1000);
        rd(2'd1, v); chk("R9 write wins", v, 1000);
        repeat (5) @(negedge clk);
        rd(2'd1, v); chk("R10 counts after write", v, 1005);

        // R5 internal wrap with period 0: match every cycle
        cfg(0, 0);
        m0 = n_match;
        repeat (20) @(negedge clk);
        chk("R5 period0 matches", n_match - m0, 20);
        wr(2'd0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule